// File: doc/BRIEF.md
# Dual-Bank Clock Output Controller

This block sits between an external frequency-multiplying PLL model and the output pads of a clock generator. It serves two banks of five clock outputs and one reference output. For each bank it works out which multiplication ratio the PLL must produce and whether spread-spectrum modulation is requested, at what width. It also gates every output individually so that an output is never cut short. The ratio and spread settings come either from board-level strap pins or from a function byte in the configuration registers. One bit of that same byte chooses the source.

A test mode bypasses the PLL. Bank A then carries the input clock divided by six, bank B the input clock divided by four, and the reference output carries the input clock itself. Outside test mode the reference output is the inverted input clock.

Each bank has an enable pin that drops the pad drivers of its bank and of the reference output at once, with no regard for clock phase. Per-output enables come from two further register bytes. These enables act glitch-free: the gate only changes while the gated clock is low. An output that is disabled but still driven stays low.

Top module: `clkbank_ctrl`

## Requirements
- R1: The 2-bit ratio code on `sel_a`/`sel_b` means 00 = 1x, 01 = 2x, 10 = 3x, 11 = 4x the input clock. It is passed through unchanged from the selected source.
- R2: When `cfg_func[0]` is 1, `sel_a`, `sel_b` and `spread_on` follow the pins `pin_sel_a`, `pin_sel_b` and `pin_spread_n`. Changes to `cfg_func[6:1]` then have no effect on them.
- R3: When `cfg_func[0]` is 0, `sel_a` = `cfg_func[2:1]`, `sel_b` = `cfg_func[4:3]` and `spread_on` = `cfg_func[6]`. The pins are then ignored.
- R4: `pin_spread_n` is active low (0 requests spread). `spread_half` equals `cfg_func[5]` in both source modes: 1 means 0.5% width, 0 means 1.0%.
- R5: When `cfg_func[7]` is 0 (test mode), the following hold:
  - Bank A outputs the input clock divided by 6, high for 3 input cycles and low for 3.
  - Bank B outputs the input clock divided by 4, high for 2 cycles and low for 2.
  - Both dividers restart from low on each entry into test mode and are held low outside it and during reset.
  - Counted from the first input rising edge after entry, the bank A clock goes high after edge 2 and the bank B clock after edge 1.
- R6: `pin_oe_a` low clears `drv_a` and forces `clk_a` to 0. `pin_oe_b` low does the same for `drv_b` and `clk_b`. Either pin low clears `drv_ref` and forces `ref_out` to 0. This path is combinational.
- R7: Output enables are active high. `cfg_ena[4:0]` gates `clk_a[4:0]`, `cfg_ena[5]` gates `ref_out`, and `cfg_enb[4:0]` gates `clk_b[4:0]`. A disabled output is held at 0.
- R8: An enable change is taken up at a falling edge of the output's source clock. Every high pulse on a gated output therefore has the full high time of its source.
- R9: Outside test mode `ref_out` is the inverse of `ref_clk`. In test mode it equals `ref_clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Input reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pll_clk_a | input | 1 | Multiplied clock for bank A from the PLL model |
| pll_clk_b | input | 1 | Multiplied clock for bank B from the PLL model |
| pin_sel_a | input | 2 | Strap ratio code for bank A |
| pin_sel_b | input | 2 | Strap ratio code for bank B |
| pin_spread_n | input | 1 | Strap spread request, active low |
| pin_oe_a | input | 1 | Bank A pad enable pin |
| pin_oe_b | input | 1 | Bank B pad enable pin |
| cfg_func | input | 8 | Function byte: source select, ratio codes, spread, test mode |
| cfg_ena | input | 8 | Bank A and reference output enables |
| cfg_enb | input | 8 | Bank B output enables |
| sel_a | output | 2 | Effective ratio code for bank A |
| sel_b | output | 2 | Effective ratio code for bank B |
| spread_on | output | 1 | Effective spread-spectrum request |
| spread_half | output | 1 | Spread width: 1 = 0.5%, 0 = 1.0% |
| clk_a | output | NOUT | Bank A clock outputs |
| clk_b | output | NOUT | Bank B clock outputs |
| ref_out | output | 1 | Reference clock output |
| drv_a | output | 1 | Pad driver enable for bank A |
| drv_b | output | 1 | Pad driver enable for bank B |
| drv_ref | output | 1 | Pad driver enable for the reference output |

## Verification
The bench toggles output enables at odd offsets inside the high phase of the PLL clocks and measures every high pulse. A gate that switched mid-phase would show up as a shortened pulse. It enters test mode twice and compares the divided clocks cycle by cycle from the entry edge. A divider that kept its count across exits, or had the wrong ratio or duty, would be off in phase or width. It flips the source-select bit while the ignored inputs change, which catches a mux that leaks the wrong source. It also checks the reference polarity in both modes.

// File: rtl/clkbank_ctrl.sv
module clkbank_ctrl #(
  parameter int NOUT = 5
) (
  input  logic            ref_clk,
  input  logic            rst_n,
  input  logic            pll_clk_a,
  input  logic            pll_clk_b,
  input  logic [1:0]      pin_sel_a,
  input  logic [1:0]      pin_sel_b,
  input  logic            pin_spread_n,
  input  logic            pin_oe_a,
  input  logic            pin_oe_b,
  input  logic [7:0]      cfg_func,
  input  logic [7:0]      cfg_ena,
  input  logic [7:0]      cfg_enb,
  output logic [1:0]      sel_a,
  output logic [1:0]      sel_b,
  output logic            spread_on,
  output logic            spread_half,
  output logic [NOUT-1:0] clk_a,
  output logic [NOUT-1:0] clk_b,
  output logic            ref_out,
  output logic            drv_a,
  output logic            drv_b,
  output logic            drv_ref
);

  logic hw_src, test_m;
  assign hw_src = cfg_func[0];
  assign test_m = ~cfg_func[7];

  assign sel_a       = hw_src ? pin_sel_a     : cfg_func[2:1];
  assign sel_b       = hw_src ? pin_sel_b     : cfg_func[4:3];
  assign spread_on   = hw_src ? ~pin_spread_n : cfg_func[6];
  assign spread_half = cfg_func[5];

  logic [1:0] cnt6;
  logic       ph6, tg4, ph4;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt6 <= '0;
      ph6  <= 1'b0;
      tg4  <= 1'b0;
      ph4  <= 1'b0;
    end else if (!test_m) begin
      cnt6 <= '0;
      ph6  <= 1'b0;
      tg4  <= 1'b0;
      ph4  <= 1'b0;
    end else begin
      if (cnt6 == 2'd2) begin
        cnt6 <= '0;
        ph6  <= ~ph6;
      end else begin
        cnt6 <= cnt6 + 2'd1;
      end
      tg4 <= ~tg4;
      if (tg4) ph4 <= ~ph4;
    end
  end

  logic src_a, src_b, src_r;
  assign src_a = test_m ? ph6     : pll_clk_a;
  assign src_b = test_m ? ph4     : pll_clk_b;
  assign src_r = test_m ? ref_clk : ~ref_clk;

  logic [NOUT-1:0] en_a, en_b;
  logic            en_r;

  always_ff @(negedge src_a or negedge rst_n)
    if (!rst_n) en_a <= '1;
    else        en_a <= cfg_ena[NOUT-1:0];

  always_ff @(negedge src_b or negedge rst_n)
    if (!rst_n) en_b <= '1;
    else        en_b <= cfg_enb[NOUT-1:0];

  always_ff @(negedge src_r or negedge rst_n)
    if (!rst_n) en_r <= 1'b1;
    else        en_r <= cfg_ena[5];

  assign drv_a   = pin_oe_a;
  assign drv_b   = pin_oe_b;
  assign drv_ref = pin_oe_a & pin_oe_b;

  assign clk_a   = pin_oe_a ? ({NOUT{src_a}} & en_a) : '0;
  assign clk_b   = pin_oe_b ? ({NOUT{src_b}} & en_b) : '0;
  assign ref_out = drv_ref & src_r & en_r;

endmodule

// File: rtl/clkbank_ctrl_chk.sv
module clkbank_ctrl_chk #(
  parameter int NOUT = 5
) (
  input logic            ref_clk,
  input logic            rst_n,
  input logic            pll_clk_a,
  input logic [1:0]      pin_sel_a,
  input logic [1:0]      pin_sel_b,
  input logic            pin_oe_a,
  input logic            pin_oe_b,
  input logic [7:0]      cfg_func,
  input logic [7:0]      cfg_ena,
  input logic [7:0]      cfg_enb,
  input logic [1:0]      sel_a,
  input logic [1:0]      sel_b,
  input logic            spread_on,
  input logic [NOUT-1:0] clk_a,
  input logic [NOUT-1:0] clk_b,
  input logic            drv_b,
  input logic            drv_ref
);

  a_r2_pins_hold: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (cfg_func[0] && $past(cfg_func[0]) && $stable(pin_sel_a) && $stable(pin_sel_b))
      |-> ($stable(sel_a) && $stable(sel_b)));

  a_r3_regs_hold: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (!cfg_func[0] && !$past(cfg_func[0]) && $stable(cfg_func[6:1]))
      |-> $stable({sel_a, sel_b, spread_on}));

  a_r5_div4_period: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (!cfg_func[7] && !$past(cfg_func[7], 3) && $past(rst_n, 3) &&
     cfg_enb[0] && $past(cfg_enb[0], 3) && pin_oe_b && $past(pin_oe_b, 3))
      |-> (clk_b[0] != $past(clk_b[0], 2)));

  a_r6_oe_b_drops: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !pin_oe_b |-> (!drv_b && !drv_ref && clk_b == '0));

  a_r7_off_low: assert property (@(negedge pll_clk_a) disable iff (!rst_n || !pin_oe_a || !cfg_func[7])
    ($past(rst_n) && $past(cfg_func[7]) && !$past(cfg_ena[0])) |-> !clk_a[0]);

  a_r8_full_high: assert property (@(negedge pll_clk_a) disable iff (!rst_n || !pin_oe_a || !cfg_func[7])
    ($past(rst_n) && $past(cfg_func[7]) && $past(cfg_ena[0])) |-> clk_a[0]);

endmodule

bind clkbank_ctrl clkbank_ctrl_chk #(.NOUT(NOUT)) u_chk (
  .ref_clk(ref_clk), .rst_n(rst_n), .pll_clk_a(pll_clk_a),
  .pin_sel_a(pin_sel_a), .pin_sel_b(pin_sel_b),
  .pin_oe_a(pin_oe_a), .pin_oe_b(pin_oe_b),
  .cfg_func(cfg_func), .cfg_ena(cfg_ena), .cfg_enb(cfg_enb),
  .sel_a(sel_a), .sel_b(sel_b), .spread_on(spread_on),
  .clk_a(clk_a), .clk_b(clk_b), .drv_b(drv_b), .drv_ref(drv_ref)
);

// File: tb/tb_clkbank_ctrl.sv
`timescale 1ns/10ps
module tb_clkbank_ctrl;
  localparam int NOUT = 5;

  logic ref_clk = 1'b0, pll_clk_a = 1'b0, pll_clk_b = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] pin_sel_a = 2'd0, pin_sel_b = 2'd0;
  logic pin_spread_n = 1'b1, pin_oe_a = 1'b1, pin_oe_b = 1'b1;
  logic [7:0] cfg_func = 8'h21, cfg_ena = 8'hFF, cfg_enb = 8'hFF;
  logic [1:0] sel_a, sel_b;
  logic spread_on, spread_half, ref_out, drv_a, drv_b, drv_ref;
  logic [NOUT-1:0] clk_a, clk_b;

  always #10   ref_clk   = ~ref_clk;
  always #7.13 pll_clk_a = ~pll_clk_a;
  always #9.17 pll_clk_b = ~pll_clk_b;

  clkbank_ctrl #(.NOUT(NOUT)) dut (
    .ref_clk(ref_clk), .rst_n(rst_n), .pll_clk_a(pll_clk_a), .pll_clk_b(pll_clk_b),
    .pin_sel_a(pin_sel_a), .pin_sel_b(pin_sel_b), .pin_spread_n(pin_spread_n),
    .pin_oe_a(pin_oe_a), .pin_oe_b(pin_oe_b),
    .cfg_func(cfg_func), .cfg_ena(cfg_ena), .cfg_enb(cfg_enb),
    .sel_a(sel_a), .sel_b(sel_b), .spread_on(spread_on), .spread_half(spread_half),
    .clk_a(clk_a), .clk_b(clk_b), .ref_out(ref_out),
    .drv_a(drv_a), .drv_b(drv_b), .drv_ref(drv_ref)
  );

  int total = 0, bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  bit   mon_on = 0;
  int   pulses = 0, runts = 0;
  realtime ra, rb;
  always @(posedge clk_a[0]) ra = $realtime;
  always @(negedge clk_a[0]) if (mon_on) begin
    pulses++;
    if ($realtime - ra < 7.0) runts++;
  end
  always @(posedge clk_b[0]) rb = $realtime;
  always @(negedge clk_b[0]) if (mon_on) begin
    pulses++;
    if ($realtime - rb < 9.0) runts++;
  end

  task automatic t_reset;
    repeat (5) @(posedge ref_clk);
    #5;
    chk(clk_a == '0, "R5 reset bank A low", clk_a, 0);
    chk(clk_b == '0, "R5 reset bank B low", clk_b, 0);
    cfg_func = 8'hA1;
    @(posedge ref_clk); #1 rst_n = 1'b1;
    repeat (3) @(posedge ref_clk);
  endtask

  task automatic t_hw_sel;
    cfg_func = 8'hA1;
    for (int c = 0; c < 4; c++) begin
      pin_sel_a = 2'(c); pin_sel_b = 2'(3 - c);
      cfg_func[4:1] = 4'(c * 5 + 3);
      #3;
      chk(sel_a == 2'(c), "R1 R2 sel_a from pins", sel_a, c);
      chk(sel_b == 2'(3 - c), "R1 R2 sel_b from pins", sel_b, 3 - c);
    end
    pin_spread_n = 1'b0; cfg_func[6] = 1'b0; #3;
    chk(spread_on == 1'b1, "R4 spread pin active low", spread_on, 1);
    pin_spread_n = 1'b1; cfg_func[6] = 1'b1; #3;
    chk(spread_on == 1'b0, "R2 spread register ignored", spread_on, 0);
    chk(spread_half == 1'b1, "R4 width bit", spread_half, 1);
    cfg_func = 8'hA1;
  endtask

  task automatic t_reg_sel;
    cfg_func = 8'b1000_1100 | 8'h00;
    cfg_func[6] = 1'b1; cfg_func[5] = 1'b0;
    pin_sel_a = 2'd3; pin_sel_b = 2'd0; pin_spread_n = 1'b1;
    #3;
    chk(sel_a == 2'd2, "R3 sel_a from cfg_func[2:1]", sel_a, 2);
    chk(sel_b == 2'd1, "R3 sel_b from cfg_func[4:3]", sel_b, 1);
    chk(spread_on == 1'b1, "R3 spread from cfg_func[6]", spread_on, 1);
    chk(spread_half == 1'b0, "R4 width 1.0 percent", spread_half, 0);
    pin_sel_a = 2'd0; pin_sel_b = 2'd3; pin_spread_n = 1'b0; #3;
    chk(sel_a == 2'd2 && sel_b == 2'd1 && spread_on, "R3 pins ignored", {sel_a, sel_b}, 9);
    pin_spread_n = 1'b1;
    cfg_func = 8'hA1;
  endtask

  task automatic t_ref_pol;
    @(posedge ref_clk); #5;
    chk(ref_out == 1'b0, "R9 ref inverted high phase", ref_out, 0);
    @(negedge ref_clk); #5;
    chk(ref_out == 1'b1, "R9 ref inverted low phase", ref_out, 1);
  endtask

  task automatic t_oe;
    logic [NOUT-1:0] sa, sb;
    sa = '0; sb = '0;
    @(posedge ref_clk); #1 pin_oe_a = 1'b0;
    #2;
    chk(!drv_a && !drv_ref && drv_b, "R6 oe_a drops bank A and ref", {drv_a, drv_b, drv_ref}, 2);
    for (int i = 0; i < 60; i++) begin #1; sa |= clk_a; sb |= clk_b; end
    chk(sa == '0, "R6 bank A forced low", sa, 0);
    chk(sb == '1, "R6 bank B still running", sb, 31);
    pin_oe_a = 1'b1; pin_oe_b = 1'b0; #2;
    chk(drv_a && !drv_b && !drv_ref && clk_b == '0, "R6 oe_b drops bank B and ref",
        {drv_a, drv_b, drv_ref}, 4);
    @(posedge ref_clk); #1 pin_oe_b = 1'b1;
  endtask

  task automatic t_disable;
    logic [NOUT-1:0] sa, sb;
    logic sr;
    sa = '0; sb = '0; sr = 1'b0;
    cfg_ena = 8'h0A; cfg_enb = 8'h15;
    repeat (4) @(posedge ref_clk);
    for (int i = 0; i < 200; i++) begin #1; sa |= clk_a; sb |= clk_b; sr |= ref_out; end
    chk(sa == 5'b01010, "R7 bank A enable mask", sa, 10);
    chk(sb == 5'b10101, "R7 bank B enable mask", sb, 21);
    chk(sr == 1'b0, "R7 ref disabled held low", sr, 0);
    cfg_ena = 8'hFF; cfg_enb = 8'hFF;
    repeat (4) @(posedge ref_clk);
  endtask

  task automatic t_glitch;
    pulses = 0; runts = 0; mon_on = 1;
    for (int i = 0; i < 40; i++) begin
      #(3.3 + (i % 7) * 1.9);
      cfg_ena[0] = ~cfg_ena[0];
      #(2.1 + (i % 5) * 2.7);
      cfg_enb[0] = ~cfg_enb[0];
    end
    cfg_ena = 8'hFF; cfg_enb = 8'hFF;
    repeat (3) @(posedge ref_clk);
    mon_on = 0;
    chk(runts == 0, "R8 no shortened pulse", runts, 0);
    chk(pulses > 10, "R8 pulses observed", pulses, 11);
  endtask

  task automatic t_test_mode;
    int ea, eb, ok_a, ok_b;
    for (int pass = 0; pass < 2; pass++) begin
      ok_a = 1; ok_b = 1;
      @(posedge ref_clk); #1 cfg_func[7] = 1'b0;
      for (int k = 0; k < 24; k++) begin
        @(posedge ref_clk); #5;
        ea = ((k + 1) / 3) % 2;
        eb = ((k + 1) / 2) % 2;
        if (clk_a != (ea ? 5'b11111 : 5'b0)) ok_a = 0;
        if (clk_b != (eb ? 5'b11111 : 5'b0)) ok_b = 0;
        if (k == 4) chk(ref_out == 1'b1, "R9 ref equals input in test", ref_out, 1);
      end
      chk(ok_a == 1, "R5 bank A divide by 6 from entry", ok_a, 1);
      chk(ok_b == 1, "R5 bank B divide by 4 from entry", ok_b, 1);
      @(negedge ref_clk); #5;
      chk(ref_out == 1'b0, "R9 ref low phase in test", ref_out, 0);
      @(posedge ref_clk); #1 cfg_func[7] = 1'b1;
      repeat (5) @(posedge ref_clk);
    end
  endtask

  initial begin
    t_reset;
    t_hw_sel;
    t_reg_sel;
    t_ref_pol;
    t_oe;
    t_disable;
    t_glitch;
    t_test_mode;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        #2_000_000;
        chk(1'b0, "watchdog expired", 0, 1);
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule